// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is a full-duplex serial master for a framing scheme in which each word is announced by a high pulse one serial clock period wide. The pulse does not stay asserted for the whole transfer. Transmit words enter through a valid/ready input that stands in for a transmit queue. Received words leave through a valid/ready output that stands in for a receive queue. The block generates the serial clock, the frame pulse, the transmit bit and its output enable. It also samples the incoming receive bit.

The master and the remote device both launch data on the rising serial clock edge and capture it on the falling edge. The word length can be set from 4 to 16 bits, and the serial clock rate is set by a divisor. When the next word is already offered, frames follow one another with no idle period: the next frame pulse overlaps the last bit of the current word.

Top module: `fpulse_ser_master`

## Requirements
- R1: While no transfer is in progress, `sclk`, `frame`, `txOe` and `txd` are all 0. Out of reset the same holds, and `rxValid` is also 0.
- R2: A word is accepted on a clock edge where `txValid` and `txReady` are both 1. At that edge `frame` goes to 1 together with a rising `sclk`. `frame` then stays high for exactly one serial clock period.
- R3: One serial clock period is 2×D system clocks, with the high half first, where D is `cfgClkDiv`. A value of 0 is treated as 1.
- R4: The most significant bit of an accepted word is driven on the rising `sclk` edge that ends its frame period. The remaining bits follow MSB first, one per serial period, each changing only on a rising edge. `txOe` is 1 throughout the word's data bits.
- R5: The receive bit is sampled on each falling `sclk` edge of a data bit, MSB first. The assembled word appears on `rxData`, zero-extended above the word length.
- R6: The word length is the `cfgWordLen` field value (bit count). Values below 4 act as 4, and values above 16 act as 16.
- R7: `rxValid` rises on the system clock edge that follows the edge at which `sclk` falls for the last bit. It stays high, with `rxData` unchanged, until `rxReady` is seen high. A newer word replaces one that has not been taken.
- R8: The next word may be offered by the time the last bit of the current word starts. In that case its frame pulse starts on that same rising edge while `txOe` is still 1, and its MSB follows at the next rising edge.
- R9: When no further word is offered, `sclk` stays low after the last bit period ends. At the same time `txOe` and `frame` drop to 0 and `txd` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWordLen | input | 5 | Word length in bits (clamped to 4..16) |
| cfgClkDiv | input | 8 | Half serial period in system clocks |
| txData | input | 16 | Transmit word, right-aligned |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Transmit word taken this cycle |
| rxData | output | 16 | Received word, right-aligned |
| rxValid | output | 1 | Received word available |
| rxReady | input | 1 | Received word taken |
| sclk | output | 1 | Serial clock |
| frame | output | 1 | Frame pulse, one serial period per word |
| txd | output | 1 | Transmit bit (valid when txOe is 1) |
| txOe | output | 1 | Transmit output enable |
| rxd | input | 1 | Receive bit |

## Verification
On every cycle, the assertions check the following edge relations:
- The frame pulse and the output enable only start on a rising serial clock edge.
- An accepted word raises the frame pulse at the next edge.
- The transmit bit never moves on a falling edge.
- The receive strobe lands two edges after the last sample.
- The idle outputs stay quiet.

Other behaviour can only be shown by the bench scenarios, which sweep every word length against several divisors in multi-word bursts:
- bit order and the received value, checked against a modelled remote device;
- the measured widths of the clock halves and of the frame pulse;
- the frame/enable overlap between back-to-back words;
- clamping of out-of-range lengths;
- holding of an untaken received word.

// File: rtl/fpulse_pkg.sv
package fpulse_pkg;

  // Strobes from the sequencer to the datapath, each valid for one clk.
  typedef struct packed {
    logic loadHold;   // capture offered word into the holding register
    logic startWord;  // move held word into the transmit shifter
    logic shiftTx;    // advance transmit shifter by one bit
    logic sampleRx;   // shift the receive bit in
    logic finishRx;   // this sample completes the word
  } fpStrobes_t;

endpackage

// File: rtl/fpulse_ctrl.sv
module fpulse_ctrl
  import fpulse_pkg::*;
#(
  parameter int MAX_WIDTH = 16,
  parameter int MIN_WIDTH = 4,
  parameter int DIV_W     = 8,
  localparam int CNT_W    = $clog2(MAX_WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgWordLen,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  logic             txValid,
  output logic             txReady,
  output logic             sclk,
  output logic             frame,
  output logic             txOe,
  output logic [CNT_W-1:0] lenEff,
  output fpStrobes_t       str
);

  localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_WIDTH);
  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_WIDTH);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             active;
  logic             pend;
  logic             driving;
  logic [CNT_W-1:0] dataLeft;
  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] divEff;
  logic             halfDone;
  logic             riseEv;
  logic             fallEv;
  logic             nextDriving;
  logic [CNT_W-1:0] nextLeft;
  logic             frameNow;
  logic             goOn;

  // Effective configuration
  always_comb begin
    if (cfgWordLen < LEN_MIN)      lenEff = LEN_MIN;
    else if (cfgWordLen > LEN_MAX) lenEff = LEN_MAX;
    else                           lenEff = cfgWordLen;
  end

  assign divEff   = (cfgClkDiv == '0) ? DIV_W'(1) : cfgClkDiv;
  assign halfDone = (halfCnt == divEff - 1'b1);
  assign riseEv   = active ? (halfDone && !sclk) : txValid;
  assign fallEv   = active && halfDone && sclk;

  // What the serial period opened by the next rising edge will carry
  always_comb begin
    nextDriving = 1'b0;
    nextLeft    = '0;
    if (pend) begin
      nextDriving = 1'b1;
      nextLeft    = lenEff;
    end else if (driving && dataLeft > ONE) begin
      nextDriving = 1'b1;
      nextLeft    = dataLeft - ONE;
    end
    frameNow = txValid && (!nextDriving || nextLeft == ONE);
    goOn     = nextDriving || frameNow;
  end

  assign txReady       = riseEv && frameNow;
  assign txOe          = driving;
  assign str.loadHold  = txReady;
  assign str.startWord = riseEv && pend;
  assign str.shiftTx   = riseEv && !pend && driving && dataLeft > ONE;
  assign str.sampleRx  = fallEv && driving;
  assign str.finishRx  = fallEv && driving && dataLeft == ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      pend     <= 1'b0;
      driving  <= 1'b0;
      dataLeft <= '0;
      halfCnt  <= '0;
      sclk     <= 1'b0;
      frame    <= 1'b0;
    end else begin
      if (!active || halfDone) halfCnt <= '0;
      else                     halfCnt <= halfCnt + 1'b1;
      if (riseEv) begin
        active   <= goOn;
        sclk     <= goOn;
        frame    <= frameNow;
        driving  <= nextDriving;
        dataLeft <= nextLeft;
        pend     <= frameNow;
      end else if (fallEv) begin
        sclk <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!sclk && !frame && !driving)); // R1
  AST_ACCEPT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (frame && sclk)); // R2
  AST_FRAME_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frame) |-> $rose(sclk)); // R2
  AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driving) |-> $rose(sclk)); // R4

endmodule

// File: rtl/fpulse_datapath.sv
module fpulse_datapath
  import fpulse_pkg::*;
#(
  parameter int MAX_WIDTH = 16,
  parameter int MIN_WIDTH = 4,
  localparam int CNT_W    = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fpStrobes_t           str,
  input  logic [CNT_W-1:0]     lenEff,
  input  logic [MAX_WIDTH-1:0] txData,
  output logic                 txBit,
  input  logic                 rxd,
  input  logic                 rxReady,
  output logic                 rxValid,
  output logic [MAX_WIDTH-1:0] rxData
);

  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_WIDTH);

  logic [MAX_WIDTH-1:0] holdReg;
  logic [MAX_WIDTH-1:0] txSh;
  logic [MAX_WIDTH-1:0] rxSh;
  logic [MAX_WIDTH-1:0] rxMask;
  logic [CNT_W-1:0]     lenReg;
  logic                 rxDonePend;

  assign txBit  = txSh[MAX_WIDTH-1];
  assign rxMask = ~({MAX_WIDTH{1'b1}} << lenReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg    <= '0;
      txSh       <= '0;
      rxSh       <= '0;
      lenReg     <= CNT_W'(MIN_WIDTH);
      rxDonePend <= 1'b0;
      rxValid    <= 1'b0;
      rxData     <= '0;
    end else begin
      if (str.loadHold) holdReg <= txData;
      if (str.startWord) begin
        txSh   <= holdReg << (LEN_MAX - lenEff);
        lenReg <= lenEff;
      end else if (str.shiftTx) begin
        txSh <= txSh << 1;
      end
      if (str.sampleRx) rxSh <= {rxSh[MAX_WIDTH-2:0], rxd};
      rxDonePend <= str.finishRx;
      if (rxDonePend) begin
        rxValid <= 1'b1;
        rxData  <= rxSh & rxMask;
      end else if (rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  AST_RX_AFTER_LSB: assert property (@(posedge clk) disable iff (!rstN)
    str.finishRx |=> ##1 rxValid); // R7
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !rxDonePend) |=> (rxValid && $stable(rxData))); // R7

endmodule

// File: rtl/fpulse_ser_master.sv
module fpulse_ser_master
  import fpulse_pkg::*;
#(
  parameter int MAX_WIDTH = 16,
  parameter int MIN_WIDTH = 4,
  parameter int DIV_W     = 8,
  localparam int CNT_W    = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     cfgWordLen,
  input  logic [DIV_W-1:0]     cfgClkDiv,
  input  logic [MAX_WIDTH-1:0] txData,
  input  logic                 txValid,
  output logic                 txReady,
  output logic [MAX_WIDTH-1:0] rxData,
  output logic                 rxValid,
  input  logic                 rxReady,
  output logic                 sclk,
  output logic                 frame,
  output logic                 txd,
  output logic                 txOe,
  input  logic                 rxd
);

  fpStrobes_t       str;
  logic [CNT_W-1:0] lenEff;
  logic             txBit;

  fpulse_ctrl #(
    .MAX_WIDTH(MAX_WIDTH), .MIN_WIDTH(MIN_WIDTH), .DIV_W(DIV_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWordLen(cfgWordLen), .cfgClkDiv(cfgClkDiv),
    .txValid(txValid), .txReady(txReady), .sclk(sclk), .frame(frame),
    .txOe(txOe), .lenEff(lenEff), .str(str)
  );

  fpulse_datapath #(
    .MAX_WIDTH(MAX_WIDTH), .MIN_WIDTH(MIN_WIDTH)
  ) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .lenEff(lenEff), .txData(txData),
    .txBit(txBit), .rxd(rxd), .rxReady(rxReady), .rxValid(rxValid),
    .rxData(rxData)
  );

  // Line is parked low whenever the enable is off
  assign txd = txOe & txBit;

  AST_TXD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> $stable(txd)); // R4

endmodule

// File: tb/test_fpulse_ser_master.sv
module test_fpulse_ser_master;
  localparam int PER = 8;  // 125 MHz, time unit ns

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  cfgWordLen = 5'd8;
  logic [7:0]  cfgClkDiv = 8'd1;
  logic [15:0] txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [15:0] rxData;
  logic        rxValid;
  logic        rxReady = 1'b1;
  logic        sclk, frame, txd, txOe;
  logic        rxd = 1'b0;

  fpulse_ser_master i_fpulse_ser_master (
    .clk(clk), .rstN(rstN), .cfgWordLen(cfgWordLen), .cfgClkDiv(cfgClkDiv),
    .txData(txData), .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .rxReady(rxReady), .sclk(sclk), .frame(frame),
    .txd(txd), .txOe(txOe), .rxd(rxd)
  );

  always #(PER/2) clk = ~clk;

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  logic [15:0] sent [4];
  logic [15:0] resp [4];
  int effLen = 8, curDiv = 1;
  int wIdx = 0, rIdx = 0, fIdx = 0, bitIdx = 0;
  bit inWord = 0, lastFrame = 0, chkLat = 1;
  logic [15:0] got = '0;
  longint riseT = 0, lsbFallT = 0, frameRiseT = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  // Remote device model: drives on rising sclk, captures on falling sclk
  always @(posedge sclk) begin
    riseT = $time;
    #1;
    if (lastFrame) begin inWord = 1; bitIdx = 0; got = '0; end
    else if (inWord) bitIdx++;
    if (inWord) rxd = resp[wIdx][effLen-1-bitIdx];
    lastFrame = frame;
  end

  always @(negedge sclk) begin
    check($time - riseT == longint'(curDiv * PER), "R3", "sclk high time",
          $time - riseT, curDiv * PER);
    #1;
    if (inWord) begin
      check(txOe === 1'b1, "R4", "txOe during data", txOe, 1);
      got = {got[14:0], txd};
      if (bitIdx == effLen - 1) begin
        check(got == sent[wIdx], "R4", "transmitted word", got, sent[wIdx]);
        inWord = 0;
        wIdx++;
        lsbFallT = $time - 1;
      end
    end
  end

  always @(posedge frame) begin
    frameRiseT = $time;
    #1;
    check(txOe == (fIdx > 0), "R8", "txOe at frame pulse start", txOe, fIdx > 0);
    fIdx++;
  end

  always @(negedge frame)
    check($time - frameRiseT == longint'(2 * curDiv * PER), "R2", "frame width",
          $time - frameRiseT, 2 * curDiv * PER);

  always @(negedge clk) begin
    if (rxValid && rxReady) begin
      check(rxData == resp[rIdx], "R5", "received word", rxData, resp[rIdx]);
      if (chkLat)
        check($time - lsbFallT == longint'(PER + PER/2), "R7", "rxValid latency",
              $time - lsbFallT, PER + PER/2);
      rIdx++;
    end
  end

  task automatic runBurst(input int rawLen, input int div, input int n, input bit holdRx);
    logic [15:0] mask;
    cfgWordLen = rawLen[4:0];
    cfgClkDiv  = div[7:0];
    effLen = (rawLen < 4) ? 4 : ((rawLen > 16) ? 16 : rawLen);  // R6 clamp
    curDiv = (div == 0) ? 1 : div;                               // R3 zero divisor
    mask = 16'((32'd1 << effLen) - 1);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      sent[i] = seed[23:8] & mask;
      resp[i] = (~sent[i] ^ 16'h5A3C) & mask;
    end
    wIdx = 0; rIdx = 0; fIdx = 0;
    chkLat = !holdRx;
    rxReady = !holdRx;
    for (int i = 0; i < n; i++) begin
      txData = sent[i];
      txValid = 1'b1;
      forever begin
        #1;
        if (txReady) break;
        @(negedge clk);
      end
      @(posedge clk);
      #1;
    end
    txValid = 1'b0;
    if (holdRx) begin
      while (!rxValid) @(negedge clk);
      repeat (10) @(negedge clk);
      check(rxValid && rxData == resp[0], "R7", "untaken word held", rxData, resp[0]);
      rxReady = 1'b1;
    end
    while (rIdx < n) @(negedge clk);
    repeat (curDiv) @(negedge clk);
    check({sclk, frame, txOe, txd} == 4'b0 && wIdx == n, "R9", "return to idle",
          {sclk, frame, txOe, txd}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({sclk, frame, txOe, txd, rxValid, txReady} == 6'b0, "R1", "reset outputs",
          {sclk, frame, txOe, txd, rxValid, txReady}, 0);
    // Sweep all legal lengths across divisors, three-word bursts (R2 R4 R5 R8)
    for (int d = 1; d <= 3; d++)
      for (int l = 4; l <= 16; l++)
        runBurst(l, d, 3, 1'b0);
    runBurst(16, 1, 4, 1'b0);
    runBurst(2, 2, 2, 1'b0);   // R6 below minimum acts as 4
    runBurst(25, 1, 2, 1'b0);  // R6 above maximum acts as 16
    runBurst(8, 0, 2, 1'b0);   // R3 divisor 0 acts as 1
    runBurst(5, 2, 1, 1'b1);   // R7 hold until taken
    repeat (5) @(negedge clk);
    check({sclk, frame, txOe, txd} == 4'b0, "R1", "idle outputs",
          {sclk, frame, txOe, txd}, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule